// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block connects an internal request port to an 8-bit multiplexed external memory bus. Each request carries a 16-bit address, write data, a write flag and a code/data flag. The block accepts a request in one cycle. It then runs an external bus cycle with an address-latch pulse and a read, write or code-fetch strobe, and ends the cycle with a one-cycle completion pulse. For reads, that pulse comes with the byte sampled from the bus. One clock period of the block equals one oscillator period of the bus, and one bus state is two clocks.

Two configuration bytes and an external-access strap are captured on every clock while reset is held, and they stay frozen once reset is released. They set four things: the wait states for code fetches, the wait states for data accesses, a short or long address-latch pulse, and the bus mode. In multiplexed mode the lower port carries the low address and then the data. In paged mode the lower port holds the low address for the whole cycle and the upper port carries the page address and then the data. In paged mode, a code fetch that stays in the page of the previous off-chip fetch skips the address phase, and a back-to-back run of such fetches keeps the code strobe low without a gap. Code fetches in the on-chip range complete without any bus activity when the strap was high.

Top module: `xbus_ctrl`

## Requirements
- R1: While reset is held and right after it is released: ale is 0, psen_n, rd_n and wr_n are 1, hi_oe and lo_oe are 0, and busy and done are 0.
- R2: cfg0, cfg1 and ea_strap are captured only while rst_n is low. Changing them after reset has no effect on bus timing.
- R3: The code wait count comes from cfg0[6:5], coded 11=0, 10=1, 01=2, 00=3 waits. psen_n stays low for 2*(1+n) clocks in an off-chip code fetch.
- R4: The data wait count comes from cfg1[2:1], with the same coding as the code field. rd_n or wr_n stays low for 2*(1+n) clocks.
- R5: With cfg0[4]=1, ale is high for 1 clock and the address phase lasts 2 clocks. With cfg0[4]=0, ale is high for 3 clocks and the address phase lasts 4 clocks. ale is low in the last address clock, and no strobe is low while ale is high.
- R6: Multiplexed mode (cfg0[1]=1): hi_out drives A15:8 for the whole cycle, and lo_out drives A7:0 while ale is high. During the strobe, lo_out carries the write data on a write. On a read, lo_oe is 0 and the data is taken from lo_in.
- R7: Paged mode (cfg0[1]=0): lo_out drives A7:0 for the whole cycle, and hi_out drives A15:8 while ale is high. During the strobe, hi_out carries the write data on a write. On a read, hi_oe is 0 and the data is taken from hi_in.
- R8: In paged mode, an off-chip code fetch is a page hit if its A15:8 equals that of the previous off-chip code fetch and the chain has not been broken. A hit has no address phase (no ale, strobe only), even after idle cycles. A fetch with a different A15:8 runs a full cycle.
- R9: When a page-hit fetch is accepted in the completion cycle of the previous code fetch, psen_n stays low continuously across both fetches.
- R10: A data read, a data write or an on-chip fetch ends the page chain, so the next code fetch runs a full cycle.
- R11: If ea_strap was 0 at reset, every code fetch goes off-chip. If it was 1, code addresses below ONCHIP_LIMIT (0x4000) complete in the cycle after acceptance with done and done_onchip high and no bus activity, and other code addresses go off-chip.
- R12: busy is high from the cycle after acceptance until the completion cycle, where it is low. A request presented while busy is ignored and starts no bus cycle.
- R13: For code requests, req_write is ignored: wr_n never goes low.
- R14: done rises in the last strobe clock, with rdata equal to the byte on the data port at that time. Completion comes A+S clocks after the accepting edge, where A is the address-phase length and S is the strobe length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one oscillator period |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while low |
| cfg0 | input | 8 | Configuration byte 0 (code waits, latch width, bus mode) |
| cfg1 | input | 8 | Configuration byte 1 (data waits) |
| ea_strap | input | 1 | External-access strap, captured during reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_addr | input | 16 | Request address |
| req_wdata | input | 8 | Write data |
| req_write | input | 1 | 1 = write (data requests only) |
| req_code | input | 1 | 1 = code fetch, 0 = data access |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| done_onchip | output | 1 | Completion was an on-chip code fetch |
| rdata | output | 8 | Read data, valid with done |
| ale | output | 1 | Address latch enable |
| psen_n | output | 1 | Code read strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| hi_out | output | 8 | Upper port output value |
| hi_oe | output | 1 | Upper port drive enable |
| hi_in | input | 8 | Upper port input value |
| lo_out | output | 8 | Lower port output value |
| lo_oe | output | 1 | Lower port drive enable |
| lo_in | input | 8 | Lower port input value |

## Verification
The sequencing is run under four configuration sets that together cover every wait encoding for both code and data, both latch-pulse widths and both bus modes. Measured strobe lengths and completion latency tell a swapped wait field or a wrong encoding apart from a correct one. Page handling is tried with three patterns: a same-page fetch issued back to back, a same-page fetch after idle cycles, and a same-page fetch that follows a data access. The first checks that the strobe stays low without a gap, the second that a hit survives idle time, and the third that only data traffic breaks the chain. The bench also checks that an in-range fetch with the strap high stays off the bus, that a request made while busy is dropped, and that configuration inputs changed after reset are ignored.

// File: rtl/xbus_pkg.sv
// Package: shared constants, types and decode helpers for the external bus sequencer.
// Assumes an 8-bit data bus and a 16-bit address split into page (upper byte) and offset.
package xbus_pkg;
    localparam int ADDR_W   = 16;
    localparam int DATA_W   = 8;
    localparam int PAGE_LSB = 8;
    localparam int CNT_W    = 3;

    // Field positions inside the configuration bytes (decoded by the configuration latch)
    localparam int CODE_WS_HI = 6;
    localparam int CODE_WS_LO = 5;
    localparam int ALE_SHORT_BIT = 4;
    localparam int MUX_MODE_BIT = 1;
    localparam int DATA_WS_HI = 2;
    localparam int DATA_WS_LO = 1;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_STRB = 2'd2,
        ST_ONCH = 2'd3
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              write;
        logic              code;
    } bus_req_t;

    // Wait field coding: all-ones means none, all-zeros means the maximum
    function automatic logic [1:0] wait_count(input logic [1:0] field);
        return ~field;
    endfunction
endpackage

// File: rtl/xbus_cfg.sv
// Module: configuration latch.
// Captures the two configuration bytes and the access strap on every clock while
// rst_n is low and holds them afterwards. Assumes rst_n is held for at least one edge.
module xbus_cfg
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] cfg0,
    input  logic [7:0] cfg1,
    input  logic       ea_strap,
    output logic [1:0] code_wait,
    output logic [1:0] data_wait,
    output logic       ale_short,
    output logic       page_mode,
    output logic       ea_high
);
    logic cfg_unused;
    assign cfg_unused = ^{cfg0[7], cfg0[3:2], cfg0[0], cfg1[7:3], cfg1[0]};

    // Sample the straps during reset only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_wait <= wait_count(cfg0[CODE_WS_HI:CODE_WS_LO]);
            data_wait <= wait_count(cfg1[DATA_WS_HI:DATA_WS_LO]);
            ale_short <= cfg0[ALE_SHORT_BIT];
            page_mode <= ~cfg0[MUX_MODE_BIT];
            ea_high   <= ea_strap;
        end
    end
endmodule

// File: rtl/xbus_route.sv
// Module: request router and page tracker.
// Decides whether a code request is served on-chip and whether an off-chip code
// fetch hits the page of the previous one. Assumes accept pulses once per request.
module xbus_route
    import xbus_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ONCHIP_LIMIT = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              page_mode,
    input  logic              ea_high,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_code,
    input  logic              accept,
    output logic              onchip,
    output logic              page_hit
);
    localparam int PAGE_W = ADDR_W - PAGE_LSB;

    logic              chain_q;
    logic [PAGE_W-1:0] page_q;
    logic              offchip_code;

    // Classify the request currently on the port
    always_comb begin
        onchip       = req_code && ea_high && (req_addr < ONCHIP_LIMIT);
        offchip_code = req_code && !onchip;
        page_hit     = page_mode && offchip_code && chain_q &&
                       (req_addr[ADDR_W-1:PAGE_LSB] == page_q);
    end

    // Track the page of the last off-chip fetch; anything else breaks the chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= 1'b0;
            page_q  <= '0;
        end else if (accept) begin
            chain_q <= page_mode && offchip_code;
            page_q  <= req_addr[ADDR_W-1:PAGE_LSB];
        end
    end
endmodule

// File: rtl/xbus_seq.sv
// Module: bus cycle sequencer.
// Runs the address phase (optional) and the strobe phase with wait states, produces
// ale, busy and completion. Accepts a new request in its own completion cycle.
module xbus_seq
    import xbus_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] code_wait,
    input  logic [1:0] data_wait,
    input  logic       ale_short,
    input  logic       req_valid,
    input  bus_req_t   req_in,
    input  logic       onchip,
    input  logic       page_hit,
    output logic       accept,
    output seq_state_t st,
    output bus_req_t   cur,
    output logic       last_strb,
    output logic       ale,
    output logic       busy,
    output logic       done,
    output logic       done_onchip
);
    seq_state_t       st_q, st_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    bus_req_t         cur_q, cur_d;
    logic [CNT_W-1:0] addr_last;
    logic [CNT_W-1:0] strb_last;
    logic [1:0]       cur_wait;
    logic             ready;

    // Phase lengths from the latched configuration
    always_comb begin
        cur_wait  = cur_q.code ? code_wait : data_wait;
        addr_last = ale_short ? CNT_W'(1) : CNT_W'(3);
        strb_last = {cur_wait, 1'b1};
    end

    // Handshake and status decode
    always_comb begin
        last_strb   = (st_q == ST_STRB) && (cnt_q == strb_last);
        ready       = (st_q == ST_IDLE) || (st_q == ST_ONCH) || last_strb;
        accept      = req_valid && ready;
        busy        = !ready;
        done        = last_strb || (st_q == ST_ONCH);
        done_onchip = (st_q == ST_ONCH);
        ale         = (st_q == ST_ADDR) && (cnt_q != addr_last);
    end

    // Next-state logic for the phase machine
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        cur_d = cur_q;
        case (st_q)
            ST_ADDR: begin
                if (cnt_q == addr_last) begin
                    st_d  = ST_STRB;
                    cnt_d = '0;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ST_STRB: begin
                if (last_strb) st_d = ST_IDLE;
                else           cnt_d = cnt_q + CNT_W'(1);
            end
            ST_ONCH: st_d = ST_IDLE;
            default: ;
        endcase
        if (accept) begin
            cur_d = req_in;
            cnt_d = '0;
            if (onchip)        st_d = ST_ONCH;
            else if (page_hit) st_d = ST_STRB;
            else               st_d = ST_ADDR;
        end
    end

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
            cur_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            cur_q <= cur_d;
        end
    end

    assign st  = st_q;
    assign cur = cur_q;
endmodule

// File: rtl/xbus_pins.sv
// Module: pin multiplexer.
// Maps the sequencer phase and the held request onto strobes and the two byte ports
// for either bus mode, and selects the read data port. Purely combinational.
module xbus_pins
    import xbus_pkg::*;
(
    input  logic              page_mode,
    input  seq_state_t        st,
    input  bus_req_t          cur,
    input  logic              last_strb,
    input  logic [DATA_W-1:0] hi_in,
    input  logic [DATA_W-1:0] lo_in,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] hi_out,
    output logic              hi_oe,
    output logic [DATA_W-1:0] lo_out,
    output logic              lo_oe,
    output logic [DATA_W-1:0] rdata
);
    logic in_addr, in_strb, in_bus, is_wr;
    logic [DATA_W-1:0] a_hi, a_lo, dat_pin;

    // Strobe decode; code requests are always reads
    always_comb begin
        in_addr = (st == ST_ADDR);
        in_strb = (st == ST_STRB);
        in_bus  = in_addr || in_strb;
        is_wr   = cur.write && !cur.code;
        a_hi    = cur.addr[ADDR_W-1:PAGE_LSB];
        a_lo    = cur.addr[PAGE_LSB-1:0];
        psen_n  = !(in_strb && cur.code);
        rd_n    = !(in_strb && !cur.code && !cur.write);
        wr_n    = !(in_strb && is_wr);
    end

    // Port routing per bus mode
    always_comb begin
        if (page_mode) begin
            lo_out  = in_bus ? a_lo : '0;
            lo_oe   = in_bus;
            hi_out  = in_addr ? a_hi : ((in_strb && is_wr) ? cur.wdata : '0);
            hi_oe   = in_addr || (in_strb && is_wr);
            dat_pin = hi_in;
        end else begin
            hi_out  = in_bus ? a_hi : '0;
            hi_oe   = in_bus;
            lo_out  = in_addr ? a_lo : ((in_strb && is_wr) ? cur.wdata : '0);
            lo_oe   = in_addr || (in_strb && is_wr);
            dat_pin = lo_in;
        end
        rdata = (last_strb && !is_wr) ? dat_pin : '0;
    end
endmodule

// File: rtl/xbus_ctrl.sv
// Module: external memory bus sequencer, top level.
// Bridges a single-cycle request port to an 8-bit multiplexed external bus with
// separate code/data wait states, selectable latch width, paged or multiplexed mode,
// page-hit fetch shortening and on-chip code range routing.
module xbus_ctrl
    import xbus_pkg::*;
#(
    parameter logic [15:0] ONCHIP_LIMIT = 16'h4000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  cfg0,
    input  logic [7:0]  cfg1,
    input  logic        ea_strap,
    input  logic        req_valid,
    input  logic [15:0] req_addr,
    input  logic [7:0]  req_wdata,
    input  logic        req_write,
    input  logic        req_code,
    output logic        busy,
    output logic        done,
    output logic        done_onchip,
    output logic [7:0]  rdata,
    output logic        ale,
    output logic        psen_n,
    output logic        rd_n,
    output logic        wr_n,
    output logic [7:0]  hi_out,
    output logic        hi_oe,
    input  logic [7:0]  hi_in,
    output logic [7:0]  lo_out,
    output logic        lo_oe,
    input  logic [7:0]  lo_in
);
    logic [1:0] code_wait, data_wait;
    logic       ale_short, page_mode, ea_high;
    logic       onchip, page_hit, accept, last_strb;
    seq_state_t st;
    bus_req_t   cur, req_in;

    assign req_in = '{addr: req_addr, wdata: req_wdata, write: req_write, code: req_code};

    xbus_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg0(cfg0), .cfg1(cfg1), .ea_strap(ea_strap),
        .code_wait(code_wait), .data_wait(data_wait), .ale_short(ale_short),
        .page_mode(page_mode), .ea_high(ea_high)
    );

    xbus_route #(.ONCHIP_LIMIT(ONCHIP_LIMIT)) u_route (
        .clk(clk), .rst_n(rst_n), .page_mode(page_mode), .ea_high(ea_high),
        .req_addr(req_addr), .req_code(req_code), .accept(accept),
        .onchip(onchip), .page_hit(page_hit)
    );

    xbus_seq u_seq (
        .clk(clk), .rst_n(rst_n), .code_wait(code_wait), .data_wait(data_wait),
        .ale_short(ale_short), .req_valid(req_valid), .req_in(req_in),
        .onchip(onchip), .page_hit(page_hit), .accept(accept), .st(st), .cur(cur),
        .last_strb(last_strb), .ale(ale), .busy(busy), .done(done),
        .done_onchip(done_onchip)
    );

    xbus_pins u_pins (
        .page_mode(page_mode), .st(st), .cur(cur), .last_strb(last_strb),
        .hi_in(hi_in), .lo_in(lo_in), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .hi_out(hi_out), .hi_oe(hi_oe), .lo_out(lo_out), .lo_oe(lo_oe), .rdata(rdata)
    );
endmodule

// File: rtl/xbus_ctrl_chk.sv
// Module: protocol checker bound to the bus sequencer top.
// Observes only top-level ports; a counter measures read strobe length.
module xbus_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ale,
    input logic       psen_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] hi_out,
    input logic [7:0] lo_out,
    input logic       hi_oe,
    input logic       lo_oe,
    input logic       busy,
    input logic       done,
    input logic       done_onchip
);
    logic [3:0] rd_low_cnt;

    // Count consecutive low cycles of the data read strobe
    always_ff @(posedge clk) begin
        if (!rst_n)     rd_low_cnt <= '0;
        else if (!rd_n) rd_low_cnt <= rd_low_cnt + 4'd1;
        else            rd_low_cnt <= '0;
    end

    p_strobe_excl_r13: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);

    p_ale_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (psen_n && rd_n && wr_n));

    p_ale_drives_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (hi_oe && lo_oe));

    p_ale_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ale && $past(ale)) |-> ($stable(hi_out) && $stable(lo_out)));

    p_write_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (hi_oe && lo_oe));

    p_read_floats_r14: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !(hi_oe && lo_oe));

    p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_onchip_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_onchip |-> (!ale && psen_n && rd_n && wr_n && !hi_oe && !lo_oe));

    p_rd_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_n) |-> (rd_low_cnt == 4'd2 || rd_low_cnt == 4'd4 ||
                         rd_low_cnt == 4'd6 || rd_low_cnt == 4'd8));
endmodule

bind xbus_ctrl xbus_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .hi_out(hi_out), .lo_out(lo_out), .hi_oe(hi_oe), .lo_oe(lo_oe),
    .busy(busy), .done(done), .done_onchip(done_onchip)
);

// File: tb/xbus_ctrl_bench.sv
// Directed bench for the external bus sequencer; one task per scenario.
module xbus_ctrl_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cfg0 = 8'h72, cfg1 = 8'h06;
    logic ea_strap = 1'b0;
    logic req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0] req_wdata = '0;
    logic req_write = 1'b0, req_code = 1'b0;
    logic busy, done, done_onchip, ale, psen_n, rd_n, wr_n, hi_oe, lo_oe;
    logic [7:0] rdata, hi_out, lo_out;
    logic [7:0] hi_in = 8'h77, lo_in = 8'h5A;

    int checks = 0, errs = 0;

    always #2.5 clk = ~clk;

    xbus_ctrl u_xbus_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg0(cfg0), .cfg1(cfg1), .ea_strap(ea_strap),
        .req_valid(req_valid), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_write(req_write), .req_code(req_code), .busy(busy), .done(done),
        .done_onchip(done_onchip), .rdata(rdata), .ale(ale), .psen_n(psen_n),
        .rd_n(rd_n), .wr_n(wr_n), .hi_out(hi_out), .hi_oe(hi_oe), .hi_in(hi_in),
        .lo_out(lo_out), .lo_oe(lo_oe), .lo_in(lo_in)
    );

    // Results of the last observed operation
    int r_cyc, r_ale, r_psen, r_rd, r_wr, r_busy_bad, r_done, r_onc, r_psen_last;
    logic [7:0] r_hi_a, r_lo_a, r_hi_s, r_lo_s, r_rdata;
    logic r_hoe_s, r_loe_s;
    // Queued follow-on request for back-to-back tests
    logic [15:0] n_addr;
    logic n_code;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic setreq(input logic [15:0] a, input logic [7:0] d, input logic w, input logic c);
        req_addr = a; req_wdata = d; req_write = w; req_code = c; req_valid = 1'b1;
    endtask

    task automatic do_reset(input logic [7:0] c0, input logic [7:0] c1, input logic ea);
        @(negedge clk);
        rst_n = 1'b0; cfg0 = c0; cfg1 = c1; ea_strap = ea; req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    // Observe one operation; called at a negedge with the request on the port
    task automatic watch(input bit hold_next);
        r_cyc = 0; r_ale = 0; r_psen = 0; r_rd = 0; r_wr = 0; r_busy_bad = 0;
        r_done = 0; r_onc = 0; r_rdata = 0; r_psen_last = 0;
        r_hi_a = 0; r_lo_a = 0; r_hi_s = 0; r_lo_s = 0; r_hoe_s = 0; r_loe_s = 0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 1; i <= 40 && r_done == 0; i++) begin
            if (i > 1) @(negedge clk);
            r_cyc = i;
            if (ale) begin r_ale++; r_hi_a = hi_out; r_lo_a = lo_out; end
            if (!psen_n) r_psen++;
            r_psen_last = !psen_n;
            if (!rd_n || !wr_n) begin
                r_hi_s = hi_out; r_lo_s = lo_out; r_hoe_s = hi_oe; r_loe_s = lo_oe;
            end
            if (!rd_n) r_rd++;
            if (!wr_n) r_wr++;
            if (done) begin
                r_done = 1; r_rdata = rdata; r_onc = done_onchip;
                if (busy) r_busy_bad++;
                if (hold_next) setreq(n_addr, 8'h00, 1'b0, n_code);
            end else if (!busy) r_busy_bad++;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 in reset", {ale, psen_n, rd_n, wr_n, hi_oe, lo_oe, busy, done}, 8'b0111_0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {ale, psen_n, rd_n, wr_n, hi_oe, lo_oe, busy, done}, 8'b0111_0000);
    endtask

    // Multiplexed mode, no waits, short latch, strap low
    task automatic t_mux_basic;
        do_reset(8'h72, 8'h06, 1'b0);
        setreq(16'h1234, 8'h00, 1'b0, 1'b0); watch(0);
        check("R14 read latency", r_cyc, 4);
        check("R5 short ale", r_ale, 1);
        check("R4 rd len n=0", r_rd, 2);
        check("R6 addr hi/lo", {r_hi_a, r_lo_a}, 16'h1234);
        check("R6 read lo float", {r_hoe_s, r_loe_s, r_hi_s}, {2'b10, 8'h12});
        check("R14 rdata lo_in", r_rdata, 8'h5A);
        check("R12 busy window", r_busy_bad, 0);
        setreq(16'hBEEF, 8'hC3, 1'b1, 1'b0); watch(0);
        check("R6 write data lo", {r_loe_s, r_lo_s, r_hi_s}, {1'b1, 8'hC3, 8'hBE});
        check("R4 wr len n=0", r_wr, 2);
        setreq(16'h0100, 8'h00, 1'b0, 1'b1); watch(0);
        check("R11 strap low offchip", {r_onc[0], r_psen[3:0]}, {1'b0, 4'd2});
        check("R3 code n=0 latency", r_cyc, 4);
        setreq(16'h0300, 8'hFF, 1'b1, 1'b1); watch(0);
        check("R13 code ignores write", {r_wr[3:0], r_psen[3:0]}, {4'd0, 4'd2});
        cfg0 = 8'h00; cfg1 = 8'h00; ea_strap = 1'b1;
        setreq(16'h1234, 8'h00, 1'b0, 1'b0); watch(0);
        check("R2 cfg change ignored", {r_cyc[3:0], r_ale[3:0]}, {4'd4, 4'd1});
        setreq(16'h0100, 8'h00, 1'b0, 1'b1); watch(0);
        check("R2 strap change ignored", r_onc, 0);
    endtask

    // Paged mode, long latch, code 2 waits, data 1 wait, strap high
    task automatic t_paged;
        do_reset(8'h20, 8'h04, 1'b1);
        hi_in = 8'h77;
        setreq(16'h5000, 8'h00, 1'b0, 1'b1);
        n_addr = 16'h5044; n_code = 1'b1;
        watch(1);
        check("R8 first fetch miss", {r_cyc[3:0], r_ale[3:0]}, {4'd10, 4'd3});
        check("R3 code n=2 psen", r_psen, 6);
        check("R7 page addr on hi", {r_hi_a, r_lo_a}, 16'h5000);
        watch(0);
        check("R8 back-to-back hit", {r_cyc[3:0], r_ale[3:0]}, {4'd6, 4'd0});
        check("R9 psen continuous", {r_psen_last[0], r_psen[3:0]}, {1'b1, 4'd6});
        repeat (3) @(negedge clk);
        setreq(16'h50F0, 8'h00, 1'b0, 1'b1); watch(0);
        check("R8 hit after idle", {r_cyc[3:0], r_ale[3:0]}, {4'd6, 4'd0});
        setreq(16'h6000, 8'h00, 1'b0, 1'b1); watch(0);
        check("R8 new page miss", {r_cyc[3:0], r_ale[3:0]}, {4'd10, 4'd3});
        setreq(16'h6010, 8'h00, 1'b0, 1'b0); watch(0);
        check("R4 data n=1 rd", {r_cyc[3:0], r_rd[3:0]}, {4'd8, 4'd4});
        check("R7 read hi float lo addr", {r_hoe_s, r_loe_s, r_lo_s}, {2'b01, 8'h10});
        check("R7 rdata hi_in", r_rdata, 8'h77);
        setreq(16'h6020, 8'h99, 1'b1, 1'b0); watch(0);
        check("R7 write data hi", {r_hoe_s, r_hi_s, r_lo_s}, {1'b1, 8'h99, 8'h20});
        setreq(16'h6000, 8'h00, 1'b0, 1'b1); watch(0);
        check("R10 chain broken by data", {r_cyc[3:0], r_ale[3:0]}, {4'd10, 4'd3});
        setreq(16'h0200, 8'h00, 1'b0, 1'b1); watch(0);
        check("R11 onchip fetch", {r_cyc[3:0], r_onc[0], r_ale[3:0], r_psen[3:0]}, {4'd1, 1'b1, 4'd0, 4'd0});
        setreq(16'h6004, 8'h00, 1'b0, 1'b1); watch(0);
        check("R10 chain broken by onchip", r_ale, 3);
    endtask

    // A request while busy must start nothing
    task automatic t_busy_ignore;
        int extra_act;
        int saw_done;
        extra_act = 0; saw_done = 0;
        setreq(16'h6010, 8'h00, 1'b0, 1'b0);
        @(posedge clk); @(negedge clk);
        setreq(16'h7000, 8'h00, 1'b0, 1'b1);
        repeat (2) @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 20 && saw_done == 0; i++) begin
            @(negedge clk);
            if (done) saw_done = 1;
        end
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (ale || !psen_n || busy) extra_act++;
        end
        check("R12 completion seen", saw_done, 1);
        check("R12 busy request ignored", extra_act, 0);
    endtask

    // Maximum waits for both, plus remaining encodings
    task automatic t_waits;
        do_reset(8'h12, 8'h00, 1'b1);
        setreq(16'h1000, 8'h00, 1'b0, 1'b0); watch(0);
        check("R4 data n=3", {r_cyc[3:0], r_rd[3:0]}, {4'd10, 4'd8});
        setreq(16'h8000, 8'h00, 1'b0, 1'b1); watch(0);
        check("R3 code n=3", {r_cyc[3:0], r_psen[3:0]}, {4'd10, 4'd8});
        setreq(16'h8002, 8'h00, 1'b0, 1'b1); watch(0);
        check("R8 no hit in mux mode", r_ale, 1);
        do_reset(8'h52, 8'h02, 1'b0);
        setreq(16'h9000, 8'h00, 1'b0, 1'b1); watch(0);
        check("R3 code n=1", {r_cyc[3:0], r_psen[3:0]}, {4'd6, 4'd4});
        setreq(16'h9001, 8'h00, 1'b0, 1'b0); watch(0);
        check("R4 data n=2", {r_cyc[3:0], r_rd[3:0]}, {4'd8, 4'd6});
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_mux_basic();
        t_paged();
        t_busy_ignore();
        t_waits();
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule